// File: doc/BRIEF.md
# VRAM Host Access Port

This block is the path a host processor uses to reach video memory directly. It holds two 19-bit logical address pointers, one for writes and one for reads. The host loads each pointer one byte at a time through an indirect register window. A separate data port moves one byte per access and advances the matching pointer afterwards. A mode input selects how a logical address becomes a physical one. In linear mode the two are equal. In bitmap mode consecutive logical bytes alternate between two 256K banks.

The host bus has four ports, chosen by `bus_sel`:

| Code | Port |
|------|------|
| 0 | data port |
| 1 | register window |
| 2 | slot select (write-only) |
| 3 | control (write-only) |

Writing port 3 with bit 0 set performs a software reset. Writes reach memory at once. Reads pass through a one-byte prefetch buffer, so a read returns the byte fetched earlier. A small synchronous byte memory stands in for the video memory. It keeps the bank bit and the low physical address bits, so locations alias within each bank above its depth.

Top module: `vram_host_port`

## Requirements
- R1: After `rst` is asserted, the following hold. All six slots read back 0x00 and the slot select is 0. Both increment-inhibit flags are clear. `bus_oe` is 0 and `bus_rdata` is the idle byte. The first data-port read returns 0x00.
- R2: Writing one write-address slot replaces only its byte. The slots are 0 = bits 7:0, 1 = bits 15:8 and 2 = bits 18:16 in slot bits 2:0. The other address bytes keep their values.
- R3: A data-port write stores the byte at once at the current write address. The write pointer then advances by 1. There is no write buffering.
- R4: After read slot 3 (bits 7:0) or slot 4 (bits 15:8) is written, no fetch takes place. The next data-port read returns the byte already in the prefetch buffer. Reads after that return data from the new address.
- R5: Writing read slot 5 loads bits 18:16 from slot bits 2:0 and refetches the buffer from the new address. The very next data-port read therefore returns data from that address.
- R6: Bit 7 of slot 2 inhibits write-pointer advance, and bit 7 of slot 5 inhibits read-pointer advance. When a flag is clear, each data-port access advances its pointer by 1.
- R7: Pointers advance modulo 2^19, so 0x7FFFF is followed by 0x00000.
- R8: When `mode_bitmap` is 0, the physical address equals the logical address. When it is 1, the physical address is {logical[0], logical[18:1]}: even addresses go to bank 0 (0x00000–0x3FFFF) and odd addresses go to bank 1 (0x40000–0x7FFFF).
- R9: Reads of the slot select port, the control port, or slot 6 and 7 through the window do not drive the bus. On every cycle without a driven read, `bus_oe` is 0 and `bus_rdata` is `IDLE_BYTE` (0xFF by default).
- R10: A read of the register window returns the selected slot. It shows the pointer's current value, including advances. Slots 2 and 5 read as {flag, 0000, addr[18:16]}.
- R11: A control-port write with bit 0 set clears exactly what `rst` clears: pointers, flags, slot select and prefetch buffer. Memory contents are kept.
- R12: A driven read shows its data with `bus_oe` = 1 for exactly the one cycle after the `bus_rd` strobe cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_bitmap | input | 1 | 0 = linear mapping, 1 = bank-interleaved mapping |
| bus_sel | input | 2 | Port select: 0 data, 1 register window, 2 slot select, 3 control |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access (ignored while `bus_wr` is high) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data, idle byte when not driven |
| bus_oe | output | 1 | High for the cycle the block drives `bus_rdata` |

## Verification
The embedded assertions cover several rules on every cycle:
- each pointer advances by exactly one, with wrap, after an uninhibited data access;
- a pointer holds still when its flag is set;
- output enable appears only in the cycle after a read strobe, and always after a data read;
- the idle byte shows whenever output enable is low;
- a software reset returns the slot select to zero.

Only the bench scenarios can show the behaviours that depend on memory contents and history. These are the stale first byte after a low or middle slot write, the immediate refetch on a high slot write, and the bank interleave seen by reading back in the other mode. Byte-wise partial address loads and the readback layout of the high slots are also covered only by the scenarios.

// File: rtl/vhp_pkg.sv
package vhp_pkg;

    localparam int ADDR_W    = 19;
    localparam int BYTE_W    = 8;
    localparam int SEL_W     = 3;
    localparam int NUM_SLOTS = 6;
    localparam int PTR_CNT   = 2;   // index 0: write pointer, 1: read pointer
    localparam int HI_W      = ADDR_W - 2 * BYTE_W;

    typedef enum logic [1:0] {
        PORT_DATA = 2'd0,
        PORT_WIN  = 2'd1,
        PORT_SEL  = 2'd2,
        PORT_CTRL = 2'd3
    } port_e;

    typedef enum logic [1:0] {
        SLOT_LO  = 2'd0,
        SLOT_MID = 2'd1,
        SLOT_HI  = 2'd2
    } slot_e;

    typedef struct packed {
        logic              inh;
        logic [ADDR_W-1:0] addr;
    } ptr_t;

    typedef struct packed {
        logic data_wr;
        logic data_rd;
        logic win_wr;
        logic win_rd;
        logic sel_wr;
        logic soft_rst;
    } acc_t;

    // Logical to physical translation.
    function automatic logic [ADDR_W-1:0] phys_map(input logic [ADDR_W-1:0] la,
                                                  input logic bitmap);
        return bitmap ? {la[0], la[ADDR_W-1:1]} : la;
    endfunction

    // Byte seen through the register window for one slot of a pointer.
    function automatic logic [BYTE_W-1:0] slot_byte(input ptr_t p, input logic [1:0] idx);
        logic [BYTE_W-1:0] b;
        case (idx)
            SLOT_LO:  b = p.addr[BYTE_W-1:0];
            SLOT_MID: b = p.addr[2*BYTE_W-1:BYTE_W];
            default:  b = {p.inh, {(BYTE_W-1-HI_W){1'b0}}, p.addr[ADDR_W-1:2*BYTE_W]};
        endcase
        return b;
    endfunction

endpackage

// File: rtl/vhp_addr_ptr.sv
module vhp_addr_ptr
    import vhp_pkg::*;
(
    input  logic              clk,
    input  logic              clr,
    input  logic              slot_we,
    input  logic [1:0]        slot_idx,
    input  logic [BYTE_W-1:0] slot_data,
    input  logic              advance,
    output ptr_t              cur,
    output ptr_t              nxt
);

    always_comb begin
        nxt = cur;
        if (slot_we) begin
            case (slot_idx)
                SLOT_LO:  nxt.addr[BYTE_W-1:0]        = slot_data;
                SLOT_MID: nxt.addr[2*BYTE_W-1:BYTE_W] = slot_data;
                SLOT_HI: begin
                    nxt.addr[ADDR_W-1:2*BYTE_W] = slot_data[HI_W-1:0];
                    nxt.inh                     = slot_data[BYTE_W-1];
                end
                default: ;
            endcase
        end else if (advance && !cur.inh) begin
            nxt.addr = cur.addr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (clr) cur <= '0;
        else     cur <= nxt;
    end

    // R6 R7
    ptr_step_chk: assert property (@(posedge clk) disable iff (clr)
        (advance && !slot_we && !cur.inh) |=> cur.addr == $past(cur.addr) + 1'b1);

    // R6
    ptr_hold_chk: assert property (@(posedge clk) disable iff (clr)
        (advance && !slot_we && cur.inh) |=> $stable(cur));

endmodule

// File: rtl/vhp_mem.sv
module vhp_mem
    import vhp_pkg::*;
#(
    parameter int AW = 11
) (
    input  logic              clk,
    input  logic              clr,
    input  logic              we,
    input  logic [AW-1:0]     widx,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              re,
    input  logic [AW-1:0]     ridx,
    output logic [BYTE_W-1:0] q
);

    localparam int DEPTH = 1 << AW;

    logic [BYTE_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) store[widx] <= wdata;
    end

    // Prefetch buffer: the last byte fetched for the read pointer.
    always_ff @(posedge clk) begin
        if (clr)     q <= '0;
        else if (re) q <= store[ridx];
    end

endmodule

// File: rtl/vram_host_port.sv
module vram_host_port
    import vhp_pkg::*;
#(
    parameter logic [7:0] IDLE_BYTE = 8'hFF,
    parameter int         MEM_AW    = 11
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       mode_bitmap,
    input  logic [1:0] bus_sel,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       bus_oe
);

    localparam int LOW_BITS = MEM_AW - 1;

    function automatic logic [MEM_AW-1:0] mem_index(input logic [ADDR_W-1:0] pa);
        return {pa[ADDR_W-1], pa[LOW_BITS-1:0]};
    endfunction

    acc_t             acc;
    logic             clr;
    logic [SEL_W-1:0] sel_q;
    logic             ptr_sel;
    logic [1:0]       win_idx;
    logic             win_ok;

    ptr_t             p_cur [PTR_CNT];
    ptr_t             p_nxt [PTR_CNT];
    logic             p_we  [PTR_CNT];
    logic             p_adv [PTR_CNT];

    logic             fetch;
    logic [BYTE_W-1:0] buf_q;

    // Access decode: a write strobe wins over a read strobe.
    always_comb begin
        acc          = '0;
        acc.data_wr  = bus_wr && (bus_sel == PORT_DATA);
        acc.win_wr   = bus_wr && (bus_sel == PORT_WIN);
        acc.sel_wr   = bus_wr && (bus_sel == PORT_SEL);
        acc.soft_rst = bus_wr && (bus_sel == PORT_CTRL) && bus_wdata[0];
        acc.data_rd  = !bus_wr && bus_rd && (bus_sel == PORT_DATA);
        acc.win_rd   = !bus_wr && bus_rd && (bus_sel == PORT_WIN);
    end

    assign clr = rst || acc.soft_rst;

    always_ff @(posedge clk) begin
        if (clr)             sel_q <= '0;
        else if (acc.sel_wr) sel_q <= bus_wdata[SEL_W-1:0];
    end

    // Slot routing: 0..2 address the write pointer, 3..5 the read pointer.
    always_comb begin
        win_ok  = (sel_q < SEL_W'(NUM_SLOTS));
        ptr_sel = (sel_q >= SEL_W'(NUM_SLOTS / 2));
        win_idx = ptr_sel ? 2'(sel_q - SEL_W'(NUM_SLOTS / 2)) : sel_q[1:0];
    end

    assign p_adv[0] = acc.data_wr;
    assign p_adv[1] = acc.data_rd;

    for (genvar g = 0; g < PTR_CNT; g++) begin : g_ptr
        assign p_we[g] = acc.win_wr && win_ok && (ptr_sel == 1'(g));

        vhp_addr_ptr u_ptr (
            .clk      (clk),
            .clr      (clr),
            .slot_we  (p_we[g]),
            .slot_idx (win_idx),
            .slot_data(bus_wdata),
            .advance  (p_adv[g]),
            .cur      (p_cur[g]),
            .nxt      (p_nxt[g])
        );
    end

    // Refetch after every data read and after a high read-slot load only.
    assign fetch = acc.data_rd || (p_we[1] && (win_idx == SLOT_HI));

    vhp_mem #(.AW(MEM_AW)) u_mem (
        .clk  (clk),
        .clr  (clr),
        .we   (acc.data_wr),
        .widx (mem_index(phys_map(p_cur[0].addr, mode_bitmap))),
        .wdata(bus_wdata),
        .re   (fetch),
        .ridx (mem_index(phys_map(p_nxt[1].addr, mode_bitmap))),
        .q    (buf_q)
    );

    // Registered read return.
    always_ff @(posedge clk) begin
        if (clr) begin
            bus_oe    <= 1'b0;
            bus_rdata <= IDLE_BYTE;
        end else if (acc.data_rd) begin
            bus_oe    <= 1'b1;
            bus_rdata <= buf_q;
        end else if (acc.win_rd && win_ok) begin
            bus_oe    <= 1'b1;
            bus_rdata <= slot_byte(p_cur[ptr_sel], win_idx);
        end else begin
            bus_oe    <= 1'b0;
            bus_rdata <= IDLE_BYTE;
        end
    end

    // R12
    oe_cause_chk: assert property (@(posedge clk) disable iff (rst)
        bus_oe |-> $past(bus_rd));

    // R12
    data_rd_drive_chk: assert property (@(posedge clk) disable iff (rst)
        acc.data_rd |=> bus_oe);

    // R9
    idle_bus_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_oe |-> bus_rdata == IDLE_BYTE);

    // R11
    soft_rst_sel_chk: assert property (@(posedge clk) disable iff (rst)
        acc.soft_rst |=> sel_q == '0);

endmodule

// File: tb/vram_host_port_tb.sv
module vram_host_port_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic       mode_bitmap;
    logic [1:0] bus_sel;
    logic       bus_wr;
    logic       bus_rd;
    logic [7:0] bus_wdata;
    logic [7:0] bus_rdata;
    logic       bus_oe;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    vram_host_port u_dut (
        .clk        (clk),
        .rst        (rst),
        .mode_bitmap(mode_bitmap),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .bus_oe     (bus_oe)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic acc_write(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        bus_sel = s; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic acc_read(input logic [1:0] s, output logic [7:0] d, output logic o);
        @(negedge clk);
        bus_sel = s; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
        o = bus_oe;
    endtask

    task automatic set_reg(input int idx, input logic [7:0] v);
        acc_write(2'd2, 8'(idx));
        acc_write(2'd1, v);
    endtask

    task automatic get_reg(input int idx, output logic [7:0] v);
        logic o;
        acc_write(2'd2, 8'(idx));
        acc_read(2'd1, v, o);
    endtask

    task automatic set_waddr(input logic [18:0] a, input logic inh);
        set_reg(0, a[7:0]);
        set_reg(1, a[15:8]);
        set_reg(2, {inh, 4'b0, a[18:16]});
    endtask

    task automatic set_raddr(input logic [18:0] a, input logic inh);
        set_reg(3, a[7:0]);
        set_reg(4, a[15:8]);
        set_reg(5, {inh, 4'b0, a[18:16]});
    endtask

    task automatic data_rd(input string tag, input logic [7:0] exp);
        logic [7:0] d;
        logic       o;
        acc_read(2'd0, d, o);
        chk(tag, d, exp);
    endtask

    task automatic t_reset;
        logic [7:0] v;
        logic       o;
        chk("R1 idle oe after reset", {7'b0, bus_oe}, 8'h00);
        chk("R1 idle data after reset", bus_rdata, 8'hFF);
        for (int i = 0; i < 6; i++) begin
            get_reg(i, v);
            chk("R1 slot zero", v, 8'h00);
        end
        acc_read(2'd0, v, o);
        chk("R1 first data read", v, 8'h00);
        chk("R12 oe on data read", {7'b0, o}, 8'h01);
        @(negedge clk);
        chk("R12 oe one cycle", {7'b0, bus_oe}, 8'h00);
    endtask

    task automatic t_write_partial;
        logic [7:0] v;
        set_waddr(19'h00010, 1'b0);
        acc_write(2'd0, 8'hA1);
        acc_write(2'd0, 8'hB2);
        acc_write(2'd0, 8'hD4);
        get_reg(0, v);
        chk("R3 write advance", v, 8'h13);
        set_reg(1, 8'h02);
        get_reg(0, v);
        chk("R2 low kept", v, 8'h13);
        get_reg(1, v);
        chk("R2 mid set", v, 8'h02);
        get_reg(2, v);
        chk("R2 high kept", v, 8'h00);
        acc_write(2'd0, 8'hC3);   // at 0x00213
    endtask

    task automatic t_read_stale;
        set_raddr(19'h00010, 1'b1);
        data_rd("R5 high refetch", 8'hA1);
        set_reg(3, 8'h12);
        data_rd("R4 stale after low", 8'hA1);
        data_rd("R4 new low addr", 8'hD4);
        set_reg(3, 8'h13);
        set_reg(4, 8'h02);
        data_rd("R4 stale after mid", 8'hD4);
        data_rd("R4 new mid addr", 8'hC3);
        set_raddr(19'h00011, 1'b1);
        data_rd("R5 refetch again", 8'hB2);
        data_rd("R6 read inhibit holds", 8'hB2);
    endtask

    task automatic t_read_incr;
        logic [7:0] v;
        set_raddr(19'h00010, 1'b0);
        data_rd("R6 read seq 0", 8'hA1);
        data_rd("R6 read seq 1", 8'hB2);
        data_rd("R6 read seq 2", 8'hD4);
        get_reg(3, v);
        chk("R10 read ptr shows advance", v, 8'h13);
    endtask

    task automatic t_write_inhibit;
        logic [7:0] v;
        set_waddr(19'h00030, 1'b1);
        acc_write(2'd0, 8'hE5);
        acc_write(2'd0, 8'hF6);
        get_reg(0, v);
        chk("R6 write inhibit holds", v, 8'h30);
        get_reg(2, v);
        chk("R10 high slot flag", v, 8'h80);
        set_raddr(19'h00030, 1'b0);
        data_rd("R6 overwrite same addr", 8'hF6);
    endtask

    task automatic t_wrap;
        logic [7:0] v;
        set_waddr(19'h7FFFF, 1'b0);
        acc_write(2'd0, 8'h47);
        acc_write(2'd0, 8'h48);
        get_reg(0, v);
        chk("R7 wrap low", v, 8'h01);
        get_reg(2, v);
        chk("R7 wrap high", v, 8'h00);
        set_raddr(19'h7FFFF, 1'b0);
        data_rd("R7 top byte", 8'h47);
        data_rd("R7 wrapped read", 8'h48);
    endtask

    task automatic t_mapping;
        mode_bitmap = 1'b0;
        set_waddr(19'h40005, 1'b0);
        acc_write(2'd0, 8'h5A);
        mode_bitmap = 1'b1;
        set_raddr(19'h0000B, 1'b1);
        data_rd("R8 odd to bank 1", 8'h5A);
        set_waddr(19'h0000C, 1'b0);
        acc_write(2'd0, 8'h6B);
        mode_bitmap = 1'b0;
        set_raddr(19'h00006, 1'b1);
        data_rd("R8 even to bank 0", 8'h6B);
    endtask

    task automatic t_idle_and_layout;
        logic [7:0] v;
        logic       o;
        acc_read(2'd2, v, o);
        chk("R9 select port data", v, 8'hFF);
        chk("R9 select port oe", {7'b0, o}, 8'h00);
        acc_read(2'd3, v, o);
        chk("R9 control port data", v, 8'hFF);
        chk("R9 control port oe", {7'b0, o}, 8'h00);
        acc_write(2'd2, 8'd6);
        acc_read(2'd1, v, o);
        chk("R9 unused slot oe", {7'b0, o}, 8'h00);
        chk("R9 unused slot data", v, 8'hFF);
        set_reg(5, 8'hFF);
        get_reg(5, v);
        chk("R10 high layout", v, 8'h87);
    endtask

    task automatic t_soft_reset;
        logic [7:0] v;
        set_waddr(19'h00123, 1'b1);
        acc_write(2'd2, 8'd4);
        acc_write(2'd3, 8'h01);
        acc_write(2'd1, 8'h55);   // window now points at slot 0
        get_reg(0, v);
        chk("R11 select cleared", v, 8'h55);
        get_reg(1, v);
        chk("R11 mid cleared", v, 8'h00);
        get_reg(2, v);
        chk("R11 flag cleared", v, 8'h00);
        data_rd("R11 buffer cleared", 8'h00);
        set_raddr(19'h00010, 1'b0);
        data_rd("R11 memory kept", 8'hA1);
    endtask

    initial begin
        #(5ns * 100000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1; mode_bitmap = 1'b0; bus_sel = 2'd0;
        bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = 8'h00;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_write_partial();
        t_read_stale();
        t_read_incr();
        t_write_inhibit();
        t_wrap();
        t_mapping();
        t_idle_and_layout();
        t_soft_reset();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule